// File: doc/BRIEF.md
# Four-Register File with Index Post-Increment

This block holds the four 16-bit general-purpose registers of a small processor datapath. A decoder drives it with register-to-register move commands, indexed-access commands, external load and read requests, and commands for the stack pointer and the program counter. It carries out those commands. Any register can be copied into any other register, which gives twelve legal ordered pairs. A move whose source is the same as its destination is refused and flagged as illegal.

Only registers 2 and 3 can act as index registers. An indexed access puts the selected register's current value on an address output. It can then step that register by one for a byte access or by two for a word access. Register 0 has two special paths. It can be loaded from the stack pointer value, and its value can be sent to the stack pointer and to the program counter as a jump target. The stack pointer, the program counter, the ALU and memory are outside this block.

Top module: `gpr_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register becomes 0x0000 at that edge.
- R2: `ld_en` writes `ld_data` into the register chosen by `ld_sel` at the next edge. `rd_data` always shows, without a clock delay, the register chosen by `rd_sel`.
- R3: A move with `mv_src` different from `mv_dst` copies the source register into the destination register at the next edge and leaves the source unchanged. `mv_illegal` stays low during such a move.
- R4: A move with `mv_src` equal to `mv_dst` raises `mv_illegal` in the same cycle and changes no register.
- R5: During an indexed access, `ix_sel`=0 selects register 2 and `ix_sel`=1 selects register 3. `ix_addr` shows the selected register's value from before any increment, in the same cycle.
- R6: With `ix_inc`=1, the selected index register grows by 1 when `ix_word`=0 and by 2 when `ix_word`=1, wrapping modulo 65536. With `ix_inc`=0 the register keeps its value.
- R7: When several writes hit the same register in one cycle, the order of priority is: move, then stack-pointer load, then external load, then post-increment.
- R8: `sp_load_r0` copies `sp_in` into register 0 at the next edge. `r0_to_sp` raises `sp_we` in the same cycle, with `sp_out` equal to register 0.
- R9: `jmp_req` raises `pc_we` in the same cycle, with `pc_target` equal to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mv_en | input | 1 | Move command strobe |
| mv_src | input | 2 | Move source register |
| mv_dst | input | 2 | Move destination register |
| mv_illegal | output | 1 | Move requested with source equal to destination |
| ld_en | input | 1 | External load strobe |
| ld_sel | input | 2 | External load target register |
| ld_data | input | 16 | External load value |
| rd_sel | input | 2 | Read port register select |
| rd_data | output | 16 | Read port value |
| ix_en | input | 1 | Indexed access strobe |
| ix_sel | input | 1 | Index register select (0: reg 2, 1: reg 3) |
| ix_inc | input | 1 | Post-increment enable |
| ix_word | input | 1 | Access size (0: byte, 1: word) |
| ix_addr | output | 16 | Address from the index register, before the increment |
| sp_in | input | 16 | Stack pointer value offered to register 0 |
| sp_load_r0 | input | 1 | Load register 0 from `sp_in` |
| r0_to_sp | input | 1 | Request to copy register 0 into the stack pointer |
| sp_out | output | 16 | Value for the stack pointer |
| sp_we | output | 1 | Stack pointer write enable |
| jmp_req | input | 1 | Register-indirect jump or subroutine call |
| pc_target | output | 16 | Jump target for the program counter |
| pc_we | output | 1 | Program counter write enable |

## Verification
A wrong register value shows at `rd_data` as soon as that register is selected, and one clock after the write that caused it. The same error also shows in the same cycle at `ix_addr`, `sp_out` or `pc_target` whenever those paths select the register. If write priority is resolved wrongly, the destination register holds the lower-priority value after the colliding edge. A faulty illegal-move check either leaves `mv_illegal` at the wrong level in the command cycle, or corrupts the destination register, which shows on the next read.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   // which write source a register accepts in a cycle
   typedef enum logic [2:0] {
      WSRC_NONE = 3'd0,
      WSRC_MOVE = 3'd1,
      WSRC_SP   = 3'd2,
      WSRC_EXT  = 3'd3,
      WSRC_INC  = 3'd4
   } wsrc_e;

endpackage

// File: rtl/gpr_index_unit.sv
module gpr_index_unit #(
   parameter int DATA_W    = 16,
   parameter int BYTE_STEP = 1,
   parameter int WORD_STEP = 2
) (
   input  logic              ix_en,
   input  logic              ix_sel,
   input  logic              ix_inc,
   input  logic              ix_word,
   input  logic [DATA_W-1:0] base_lo,
   input  logic [DATA_W-1:0] base_hi,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] inc_val,
   output logic [1:0]        inc_req
);

   localparam logic [DATA_W-1:0] STEP_B = DATA_W'(BYTE_STEP);
   localparam logic [DATA_W-1:0] STEP_W = DATA_W'(WORD_STEP);

   if (BYTE_STEP < 1 || WORD_STEP < 1) begin : g_bad_step
      $error("gpr_index_unit: steps must be positive");
   end

   logic [DATA_W-1:0] step;

   generate
      if (BYTE_STEP == WORD_STEP) begin : g_one_step
         assign step = STEP_B;
      end else begin : g_two_step
         assign step = ix_word ? STEP_W : STEP_B;
      end
   endgenerate

   always_comb begin
      addr    = ix_sel ? base_hi : base_lo;
      inc_val = addr + step;
      inc_req = 2'b00;
      if (ix_en && ix_inc) begin
         inc_req[ix_sel] = 1'b1;
      end
   end

endmodule

// File: rtl/gpr_wr_ctrl.sv
module gpr_wr_ctrl
   import gpr_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit HAS_SP  = 1'b0,
   parameter bit HAS_INC = 1'b0
) (
   input  logic              mv_hit,
   input  logic [DATA_W-1:0] mv_val,
   input  logic              sp_hit,
   input  logic [DATA_W-1:0] sp_val,
   input  logic              ext_hit,
   input  logic [DATA_W-1:0] ext_val,
   input  logic              inc_hit,
   input  logic [DATA_W-1:0] inc_val,
   output logic              we,
   output logic [DATA_W-1:0] wd
);

   logic  sp_ok;
   logic  inc_ok;
   wsrc_e src;

   generate
      if (HAS_SP) begin : g_sp
         assign sp_ok = sp_hit;
      end else begin : g_no_sp
         assign sp_ok = 1'b0;
      end
      if (HAS_INC) begin : g_inc
         assign inc_ok = inc_hit;
      end else begin : g_no_inc
         assign inc_ok = 1'b0;
      end
   endgenerate

   // fixed priority: move, stack pointer, external, increment
   always_comb begin
      if (mv_hit)       src = WSRC_MOVE;
      else if (sp_ok)   src = WSRC_SP;
      else if (ext_hit) src = WSRC_EXT;
      else if (inc_ok)  src = WSRC_INC;
      else              src = WSRC_NONE;
   end

   always_comb begin
      we = (src != WSRC_NONE);
      unique case (src)
         WSRC_MOVE: wd = mv_val;
         WSRC_SP:   wd = sp_val;
         WSRC_EXT:  wd = ext_val;
         WSRC_INC:  wd = inc_val;
         default:   wd = '0;
      endcase
   end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
   parameter int DATA_W    = 16,
   parameter int NUM_REGS  = 4,
   parameter int BYTE_STEP = 1,
   parameter int WORD_STEP = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        mv_en,
   input  logic [1:0]  mv_src,
   input  logic [1:0]  mv_dst,
   output logic        mv_illegal,
   input  logic        ld_en,
   input  logic [1:0]  ld_sel,
   input  logic [15:0] ld_data,
   input  logic [1:0]  rd_sel,
   output logic [15:0] rd_data,
   input  logic        ix_en,
   input  logic        ix_sel,
   input  logic        ix_inc,
   input  logic        ix_word,
   output logic [15:0] ix_addr,
   input  logic [15:0] sp_in,
   input  logic        sp_load_r0,
   input  logic        r0_to_sp,
   output logic [15:0] sp_out,
   output logic        sp_we,
   input  logic        jmp_req,
   output logic [15:0] pc_target,
   output logic        pc_we
);

   localparam int SEL_W = $clog2(NUM_REGS);
   localparam int IX_LO = 2;
   localparam int IX_HI = 3;

   if (NUM_REGS != 4) begin : g_bad_regs
      $error("gpr_bank: port widths fix NUM_REGS at 4");
   end
   if (DATA_W != 16) begin : g_bad_width
      $error("gpr_bank: port widths fix DATA_W at 16");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] wd;
   logic [NUM_REGS-1:0]             we;

   logic              mv_ok;
   logic [DATA_W-1:0] mv_val;
   logic [DATA_W-1:0] inc_val;
   logic [1:0]        inc_req;
   logic [SEL_W-1:0]  ix_tgt;
   logic              tgt_over;

   assign mv_illegal = mv_en && (mv_src == mv_dst);
   assign mv_ok      = mv_en && (mv_src != mv_dst);
   assign mv_val     = regs_q[mv_src];
   assign rd_data    = regs_q[rd_sel];

   assign sp_out     = regs_q[0];
   assign sp_we      = r0_to_sp;
   assign pc_target  = regs_q[0];
   assign pc_we      = jmp_req;

   gpr_index_unit #(
      .DATA_W   (DATA_W),
      .BYTE_STEP(BYTE_STEP),
      .WORD_STEP(WORD_STEP)
   ) u_ix (
      .ix_en  (ix_en),
      .ix_sel (ix_sel),
      .ix_inc (ix_inc),
      .ix_word(ix_word),
      .base_lo(regs_q[IX_LO]),
      .base_hi(regs_q[IX_HI]),
      .addr   (ix_addr),
      .inc_val(inc_val),
      .inc_req(inc_req)
   );

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic inc_hit;
         if (g == IX_LO) begin : g_lo
            assign inc_hit = inc_req[0];
         end else if (g == IX_HI) begin : g_hi
            assign inc_hit = inc_req[1];
         end else begin : g_none
            assign inc_hit = 1'b0;
         end

         gpr_wr_ctrl #(
            .DATA_W (DATA_W),
            .HAS_SP (g == 0),
            .HAS_INC(g == IX_LO || g == IX_HI)
         ) u_wr (
            .mv_hit (mv_ok && (mv_dst == SEL_W'(g))),
            .mv_val (mv_val),
            .sp_hit (sp_load_r0),
            .sp_val (sp_in),
            .ext_hit(ld_en && (ld_sel == SEL_W'(g))),
            .ext_val(ld_data),
            .inc_hit(inc_hit),
            .inc_val(inc_val),
            .we     (we[g]),
            .wd     (wd[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         regs_q <= '0;
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (we[i]) regs_q[i] <= wd[i];
         end
      end
   end

   // helpers for the checks below
   assign ix_tgt   = ix_sel ? SEL_W'(IX_HI) : SEL_W'(IX_LO);
   assign tgt_over = (mv_ok && mv_dst == ix_tgt) || (ld_en && ld_sel == ix_tgt);

   // R1
   rst_clear_chk: assert property (@(posedge clk) rst |=> (regs_q == '0));

   // R3
   move_copy_chk: assert property (@(posedge clk) disable iff (rst)
      mv_ok |=> regs_q[$past(mv_dst)] == $past(mv_val));

   // R4
   illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mv_illegal && !ld_en && !sp_load_r0 && !ix_en) |=> $stable(regs_q));

   // R6
   postinc_chk: assert property (@(posedge clk) disable iff (rst)
      (ix_en && ix_inc && !tgt_over) |=> regs_q[$past(ix_tgt)] == $past(ix_addr) + (($past(ix_word) && WORD_STEP != BYTE_STEP) ? DATA_W'(WORD_STEP) : DATA_W'(BYTE_STEP)));

   // R8
   sp_load_chk: assert property (@(posedge clk) disable iff (rst)
      (sp_load_r0 && !(mv_ok && mv_dst == '0)) |=> regs_q[0] == $past(sp_in));

endmodule

// File: tb/sim_gpr_bank.sv
module sim_gpr_bank;

   localparam int CLK_PERIOD = 10;

   // {illegal, src[1:0], dst[1:0]}
   localparam logic [4:0] MV_TAB [14] = '{
      5'h01, 5'h02, 5'h03, 5'h04, 5'h06, 5'h07, 5'h08,
      5'h09, 5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h10, 5'h1F
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        mv_en, mv_illegal, ld_en, ix_en, ix_sel, ix_inc, ix_word;
   logic [1:0]  mv_src, mv_dst, ld_sel, rd_sel;
   logic [15:0] ld_data, rd_data, ix_addr, sp_in, sp_out, pc_target;
   logic        sp_load_r0, r0_to_sp, sp_we, jmp_req, pc_we;

   int n_chk  = 0;
   int n_fail = 0;
   logic [15:0] mdl [4];

   gpr_bank u0 (
      .clk(clk), .rst(rst),
      .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst), .mv_illegal(mv_illegal),
      .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .ix_en(ix_en), .ix_sel(ix_sel), .ix_inc(ix_inc), .ix_word(ix_word), .ix_addr(ix_addr),
      .sp_in(sp_in), .sp_load_r0(sp_load_r0), .r0_to_sp(r0_to_sp),
      .sp_out(sp_out), .sp_we(sp_we),
      .jmp_req(jmp_req), .pc_target(pc_target), .pc_we(pc_we)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      mv_en = 0; mv_src = 0; mv_dst = 0; ld_en = 0; ld_sel = 0; ld_data = 0;
      ix_en = 0; ix_sel = 0; ix_inc = 0; ix_word = 0;
      sp_in = 0; sp_load_r0 = 0; r0_to_sp = 0; jmp_req = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic rd(input logic [1:0] s, output logic [15:0] v);
      rd_sel = s;
      #1;
      v = rd_data;
   endtask

   task automatic load(input logic [1:0] s, input logic [15:0] v);
      ld_en = 1; ld_sel = s; ld_data = v;
      tick();
      mdl[s] = v;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [15:0] v;
      rst = 1; rd_sel = 0; idle();
      tick(); tick();
      rst = 0;

      // R1: reset state
      for (int r = 0; r < 4; r++) begin
         rd(2'(r), v);
         chk("R1 reset value", v, 16'h0000);
      end

      // R2 R3 R4: table walk
      for (int i = 0; i < 14; i++) begin
         logic [1:0] s, d;
         logic ill;
         ill = MV_TAB[i][4];
         s = MV_TAB[i][3:2];
         d = MV_TAB[i][1:0];
         for (int r = 0; r < 4; r++) begin
            load(2'(r), 16'h1000 * 16'(r + 1) + 16'(i * 17));
         end
         rd(d, v);
         chk("R2 load/read", v, mdl[d]);
         mv_en = 1; mv_src = s; mv_dst = d;
         #1;
         chk(ill ? "R4 illegal flag" : "R3 legal flag low", {15'd0, mv_illegal}, {15'd0, ill});
         tick();
         if (!ill) mdl[d] = mdl[s];
         for (int r = 0; r < 4; r++) begin
            rd(2'(r), v);
            chk(ill ? "R4 no register change" : "R3 move result", v, mdl[r]);
         end
      end

      // R5 R6: index on register 2, word then byte then no increment
      load(2, 16'h0100);
      ix_en = 1; ix_sel = 0; ix_inc = 1; ix_word = 1;
      #1; chk("R5 ix_addr pre-increment", ix_addr, 16'h0100);
      tick();
      rd(2, v); chk("R6 word step", v, 16'h0102);
      ix_en = 1; ix_sel = 0; ix_inc = 1; ix_word = 0;
      #1; chk("R5 ix_addr reg2", ix_addr, 16'h0102);
      tick();
      rd(2, v); chk("R6 byte step", v, 16'h0103);
      ix_en = 1; ix_sel = 0; ix_inc = 0; ix_word = 1;
      tick();
      rd(2, v); chk("R6 no increment", v, 16'h0103);

      // R5 R6: register 3 wraps
      load(3, 16'hFFFF);
      ix_en = 1; ix_sel = 1; ix_inc = 1; ix_word = 0;
      #1; chk("R5 ix_addr reg3", ix_addr, 16'hFFFF);
      tick();
      rd(3, v); chk("R6 wrap", v, 16'h0000);
      rd(2, v); chk("R6 other index untouched", v, 16'h0103);

      // R7: move beats increment
      load(3, 16'h0040);
      load(1, 16'h7777);
      mv_en = 1; mv_src = 1; mv_dst = 3;
      ix_en = 1; ix_sel = 1; ix_inc = 1; ix_word = 1;
      tick();
      rd(3, v); chk("R7 move over increment", v, 16'h7777);

      // R7: external load beats increment
      ld_en = 1; ld_sel = 2; ld_data = 16'h2222;
      ix_en = 1; ix_sel = 0; ix_inc = 1; ix_word = 1;
      tick();
      rd(2, v); chk("R7 load over increment", v, 16'h2222);

      // R7: stack-pointer load beats external load
      sp_load_r0 = 1; sp_in = 16'h5A5A;
      ld_en = 1; ld_sel = 0; ld_data = 16'h1111;
      tick();
      rd(0, v); chk("R7 sp over load", v, 16'h5A5A);

      // R8: stack pointer paths
      sp_load_r0 = 1; sp_in = 16'hBEEF;
      tick();
      rd(0, v); chk("R8 r0 from sp", v, 16'hBEEF);
      r0_to_sp = 1;
      #1;
      chk("R8 sp_we", {15'd0, sp_we}, 16'h0001);
      chk("R8 sp_out", sp_out, 16'hBEEF);
      tick();
      chk("R8 sp_we idle", {15'd0, sp_we}, 16'h0000);

      // R9: jump target
      jmp_req = 1;
      #1;
      chk("R9 pc_we", {15'd0, pc_we}, 16'h0001);
      chk("R9 pc_target", pc_target, 16'hBEEF);
      tick();

      // R1: reset after activity
      rst = 1;
      tick();
      rst = 0;
      for (int r = 0; r < 4; r++) begin
         rd(2'(r), v);
         chk("R1 reset clears", v, 16'h0000);
      end

      summary();
   end

endmodule